// File: doc/BRIEF.md
# Credit-Limited Transmit Chunk Packer

This block sits between a MAC transmit path and an SPI data-channel shifter. Outgoing Ethernet frames arrive as a byte stream with first-byte and last-byte markers. The block cuts them into fixed-size chunks for a serial burst. Each chunk is a 32-bit header, sent most significant byte first, followed by a payload of `PAYLOAD_BYTES` bytes (64 by default). A frame always begins at the start of a chunk. Its final piece may be shorter than the payload, and the unused bytes are sent as zeros.

A burst begins when `burst_start` is pulsed while the block is idle. At that moment the block captures three things: the transmit credit count reported by the device, the number of receive chunks the device has waiting, and a pending-interrupt flag.

The block then builds data chunks. It builds one only while credits remain and frame bytes are present at a chunk boundary. After the data chunks it appends empty filler chunks, so that the device can return its waiting receive chunks during the same burst. A pending interrupt with nothing else to send produces a single empty chunk. At the end of the burst, a one-cycle `burst_done` pulse reports how many chunks were sent.

Top module: `tx_chunk_packer`

## Requirements
- R1: Every chunk appears on `out_data` as `out_valid` bytes: 4 header bytes (header bits 31:24 first), then exactly `PAYLOAD_BYTES` payload bytes. The burst carries `burst_chunks` × (4 + `PAYLOAD_BYTES`) bytes in total.
- R2: Every data chunk header has the following fields:
  - bit 31 = 1 and bit 21 (data valid) = 1.
  - bit 20 = start flag and bit 14 = end flag.
  - bits 13:8 = end offset.
  - bits 19:16 = 0, and all other bits = 0 except bit 0.
  - bit 0 is chosen so that the 32-bit word holds an odd number of ones.
- R3: The payload carries the frame bytes in arrival order, up to `PAYLOAD_BYTES` per chunk. A chunk ends early only at the frame's last byte, and the payload positions after that byte are sent as 0x00.
- R4: The start flag (header bit 20) is 1 only on the chunk whose first byte was marked with `in_sof`.
- R5: The end flag (header bit 14) is 1 only on the chunk holding the byte marked `in_eof`. That chunk's end offset (bits 13:8) is the byte's payload index, which is the number of bytes in the chunk minus one. On every other chunk the end offset is 0.
- R6: A burst holds no more data chunks than min(`credits`, `MAX_CHUNKS`). Frame bytes left over stay queued at the input and continue in a later burst.
- R7: If the data chunks number fewer than `rx_avail`, empty chunks are appended to make up the difference. Each empty chunk has header 0x80000000 and an all-zero payload.
- R8: When `irq_pend` is captured and the burst would otherwise carry no chunk, exactly one empty chunk is sent. Otherwise the flag adds no chunk.
- R9: A burst never holds more than `MAX_CHUNKS` chunks in total. Filler chunks are trimmed to respect this limit.
- R10: `burst_done` is a one-cycle pulse, and while it is high `burst_chunks` equals the number of chunks sent. A burst with nothing to send ends with `burst_chunks` = 0 and no output bytes.
- R11: During and just after reset, `out_valid`, `in_ready`, `busy` and `burst_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of its frame |
| in_eof | input | 1 | Byte is the last of its frame |
| in_ready | output | 1 | Block takes the byte this cycle |
| credits | input | CNT_W | Transmit credits, captured at burst start |
| rx_avail | input | CNT_W | Receive chunks waiting in the device, captured at burst start |
| irq_pend | input | 1 | Interrupt pending, captured at burst start |
| burst_start | input | 1 | Begin a burst (taken while idle) |
| busy | output | 1 | Burst in progress |
| out_valid | output | 1 | Chunk byte present on out_data |
| out_data | output | 8 | Chunk byte stream |
| burst_done | output | 1 | One-cycle end-of-burst pulse |
| burst_chunks | output | clog2(MAX_CHUNKS+1) | Chunks sent in the burst, valid with burst_done |

## Verification
The bench builds the block with its default parameters: 64-byte payloads, a 48-chunk burst limit and 8-bit counts. With these values a single frame of up to 200 bytes spans several chunks and crosses burst boundaries when credits are scarce. An 8-bit receive count of 60 reaches past the 48-chunk limit, so filler trimming is exercised. A credit value above 48 exercises credit clamping. Randomised frames, credit counts, receive counts and interrupt flags are checked byte for byte against chunk streams that the bench builds itself.

// File: rtl/txp_pkg.sv
// Package for the transmit chunk packer.
// Holds the sequencer state type and the header builder.
// Assumes the header layout is a fixed 32-bit word with odd parity in bit 0.
package txp_pkg;

    localparam int TXP_HDR_BYTES = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_FILL,
        ST_HDR,
        ST_PAY,
        ST_DONE
    } txp_state_t;

    // Build one data-channel header word; bit 0 makes the count of ones odd.
    function automatic logic [31:0] txp_make_hdr(input logic       dv,
                                                 input logic       sv,
                                                 input logic       ev,
                                                 input logic [5:0] eoff);
        logic [31:0] w;
        w        = '0;
        w[31]    = 1'b1;
        w[21]    = dv;
        w[20]    = sv;
        w[14]    = ev;
        w[13:8]  = eoff;
        w[0]     = ~(^w[31:1]);
        return w;
    endfunction

endpackage

// File: rtl/txp_fill.sv
// Chunk staging buffer.
// Collects up to PAYLOAD_BYTES frame bytes for one chunk. A chunk is complete
// when the buffer is full or when the frame's last byte has been taken.
// The buffer records whether the chunk began a frame, whether it ended one,
// and the index of its last valid byte.
// Reads beyond that last byte return zero, which supplies the padding.
// Assumes fill_en is high only while the sequencer is in its fill state.
module txp_fill #(
    parameter  int PAYLOAD_BYTES = 64,
    localparam int IDX_W         = $clog2(PAYLOAD_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             fill_done,
    output logic [7:0]       rd_byte,
    output logic             got_sof,
    output logic             got_eof,
    output logic [IDX_W-1:0] last_idx
);

    localparam logic [IDX_W-1:0] LAST_B = IDX_W'(PAYLOAD_BYTES - 1);

    logic [7:0]       mem [PAYLOAD_BYTES];
    logic [IDX_W-1:0] wr_idx;
    logic             take;

    // Byte accepted this cycle and whether it closes the chunk.
    always_comb begin
        take      = fill_en & in_valid;
        fill_done = take & (in_eof | (wr_idx == LAST_B));
    end

    // Payload storage; data only, so it carries no reset.
    always_ff @(posedge clk) begin
        if (take) begin
            mem[wr_idx] <= in_data;
        end
    end

    // Write pointer and per-chunk frame markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx   <= '0;
            got_sof  <= 1'b0;
            got_eof  <= 1'b0;
            last_idx <= '0;
        end else if (take) begin
            if (wr_idx == '0) begin
                got_sof <= in_sof;
            end
            if (fill_done) begin
                wr_idx   <= '0;
                got_eof  <= in_eof;
                last_idx <= wr_idx;
            end else begin
                wr_idx <= wr_idx + 1'b1;
            end
        end
    end

    // Read port with zero padding past the last valid byte.
    always_comb begin
        rd_byte = (rd_idx <= last_idx) ? mem[rd_idx] : 8'h00;
    end

endmodule

// File: rtl/txp_seq.sv
// Burst sequencer.
// Captures the credit count, the receive backlog and the interrupt flag at
// burst start. It then runs data chunks while credits remain and input bytes
// are present at a chunk boundary, and follows them with empty filler chunks.
// The total is capped at MAX_CHUNKS.
// It drives the byte counter shared by the header and payload phases.
// Assumes PAYLOAD_BYTES >= 4 so the byte counter also covers the header.
module txp_seq
    import txp_pkg::*;
#(
    parameter  int PAYLOAD_BYTES = 64,
    parameter  int MAX_CHUNKS    = 48,
    parameter  int CNT_W         = 8,
    localparam int IDX_W         = $clog2(PAYLOAD_BYTES),
    localparam int CW            = $clog2(MAX_CHUNKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_start,
    input  logic [CNT_W-1:0] credits,
    input  logic [CNT_W-1:0] rx_avail,
    input  logic             irq_pend,
    input  logic             in_valid,
    input  logic             fill_done,
    output txp_state_t       state,
    output logic [IDX_W-1:0] byte_cnt,
    output logic             empty_mode,
    output logic [CW-1:0]    burst_chunks
);

    localparam int AW = ((CNT_W > CW) ? CNT_W : CW) + 1;
    localparam logic [IDX_W-1:0] LAST_B = IDX_W'(PAYLOAD_BYTES - 1);
    localparam logic [IDX_W-1:0] LAST_H = IDX_W'(TXP_HDR_BYTES - 1);

    logic [CW-1:0]    cred_q, data_cnt, tot_cnt, fill_left;
    logic [CNT_W-1:0] rxav_q;
    logic             irq_q;
    logic [CW-1:0]    cred_clamp, fill_n;
    logic [AW-1:0]    need_w, room_w, fill_w;
    logic             take_data;

    // Clamp the offered credits to the burst limit.
    always_comb begin
        cred_clamp = (AW'(credits) > AW'(MAX_CHUNKS)) ? CW'(MAX_CHUNKS) : CW'(credits);
    end

    // Filler count: cover the receive backlog, stay within the cap, honour the interrupt.
    always_comb begin
        need_w = (AW'(rxav_q) > AW'(data_cnt)) ? (AW'(rxav_q) - AW'(data_cnt)) : '0;
        room_w = AW'(MAX_CHUNKS) - AW'(data_cnt);
        fill_w = (need_w > room_w) ? room_w : need_w;
        if ((data_cnt == '0) && (fill_w == '0) && irq_q) begin
            fill_w = AW'(1);
        end
        fill_n    = CW'(fill_w);
        take_data = (data_cnt < cred_q) && in_valid;
    end

    // Burst state machine with chunk and byte counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cred_q     <= '0;
            rxav_q     <= '0;
            irq_q      <= 1'b0;
            data_cnt   <= '0;
            tot_cnt    <= '0;
            fill_left  <= '0;
            byte_cnt   <= '0;
            empty_mode <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (burst_start) begin
                        cred_q     <= cred_clamp;
                        rxav_q     <= rx_avail;
                        irq_q      <= irq_pend;
                        data_cnt   <= '0;
                        tot_cnt    <= '0;
                        empty_mode <= 1'b0;
                        state      <= ST_DECIDE;
                    end
                end
                ST_DECIDE: begin
                    byte_cnt <= '0;
                    if (take_data) begin
                        empty_mode <= 1'b0;
                        state      <= ST_FILL;
                    end else if (fill_n != '0) begin
                        empty_mode <= 1'b1;
                        fill_left  <= fill_n;
                        state      <= ST_HDR;
                    end else begin
                        state <= ST_DONE;
                    end
                end
                ST_FILL: begin
                    if (fill_done) begin
                        byte_cnt <= '0;
                        state    <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (byte_cnt == LAST_H) begin
                        byte_cnt <= '0;
                        state    <= ST_PAY;
                    end else begin
                        byte_cnt <= byte_cnt + 1'b1;
                    end
                end
                ST_PAY: begin
                    if (byte_cnt == LAST_B) begin
                        byte_cnt <= '0;
                        tot_cnt  <= tot_cnt + 1'b1;
                        if (empty_mode) begin
                            fill_left <= fill_left - 1'b1;
                            state     <= (fill_left == CW'(1)) ? ST_DONE : ST_HDR;
                        end else begin
                            data_cnt <= data_cnt + 1'b1;
                            state    <= ST_DECIDE;
                        end
                    end else begin
                        byte_cnt <= byte_cnt + 1'b1;
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Reported chunk total, meaningful while the done state is held.
    always_comb begin
        burst_chunks = tot_cnt;
    end

    // R6
    credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_cnt <= cred_q);

    // R9
    burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tot_cnt <= CW'(MAX_CHUNKS));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_IDLE));

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_DONE) && (data_cnt == '0) && (rxav_q == '0)) |-> (tot_cnt <= CW'(1)));

endmodule

// File: rtl/tx_chunk_packer.sv
// Credit-limited transmit chunk packer, top level.
// Ties the staging buffer to the burst sequencer and builds the header word.
// Selects between header bytes (most significant first), payload bytes and
// zero filler bytes for the outgoing stream.
// Assumes PAYLOAD_BYTES <= 64 so the end offset fits the 6-bit header field.
module tx_chunk_packer #(
    parameter int PAYLOAD_BYTES = 64,
    parameter int MAX_CHUNKS    = 48,
    parameter int CNT_W         = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic [7:0]                        in_data,
    input  logic                              in_sof,
    input  logic                              in_eof,
    output logic                              in_ready,
    input  logic [CNT_W-1:0]                  credits,
    input  logic [CNT_W-1:0]                  rx_avail,
    input  logic                              irq_pend,
    input  logic                              burst_start,
    output logic                              busy,
    output logic                              out_valid,
    output logic [7:0]                        out_data,
    output logic                              burst_done,
    output logic [$clog2(MAX_CHUNKS+1)-1:0]   burst_chunks
);
    import txp_pkg::*;

    localparam int IDX_W = $clog2(PAYLOAD_BYTES);

    txp_state_t       state;
    logic [IDX_W-1:0] byte_cnt, last_idx;
    logic             empty_mode, fill_done, got_sof, got_eof;
    logic [7:0]       rd_byte;
    logic [31:0]      hdr_word;
    logic [5:0]       eoff;

    txp_fill #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_en   (state == ST_FILL),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .rd_idx    (byte_cnt),
        .fill_done (fill_done),
        .rd_byte   (rd_byte),
        .got_sof   (got_sof),
        .got_eof   (got_eof),
        .last_idx  (last_idx)
    );

    txp_seq #(
        .PAYLOAD_BYTES (PAYLOAD_BYTES),
        .MAX_CHUNKS    (MAX_CHUNKS),
        .CNT_W         (CNT_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_start  (burst_start),
        .credits      (credits),
        .rx_avail     (rx_avail),
        .irq_pend     (irq_pend),
        .in_valid     (in_valid),
        .fill_done    (fill_done),
        .state        (state),
        .byte_cnt     (byte_cnt),
        .empty_mode   (empty_mode),
        .burst_chunks (burst_chunks)
    );

    // Header word for the chunk about to be sent.
    always_comb begin
        eoff     = got_eof ? 6'(last_idx) : 6'd0;
        hdr_word = empty_mode ? txp_make_hdr(1'b0, 1'b0, 1'b0, 6'd0)
                              : txp_make_hdr(1'b1, got_sof, got_eof, eoff);
    end

    // Output byte select and status strobes.
    always_comb begin
        in_ready   = (state == ST_FILL);
        busy       = (state != ST_IDLE);
        burst_done = (state == ST_DONE);
        out_valid  = (state == ST_HDR) || (state == ST_PAY);
        out_data   = 8'h00;
        if (state == ST_HDR) begin
            case (byte_cnt[1:0])
                2'd0:    out_data = hdr_word[31:24];
                2'd1:    out_data = hdr_word[23:16];
                2'd2:    out_data = hdr_word[15:8];
                default: out_data = hdr_word[7:0];
            endcase
        end else if ((state == ST_PAY) && !empty_mode) begin
            out_data = rd_byte;
        end
    end

    // R1
    no_io_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && in_ready));

endmodule

// File: tb/tb_tx_chunk_packer.sv
`timescale 1ns/1ps
module tb_tx_chunk_packer;

    localparam int P    = 64;
    localparam int MAXC = 48;
    localparam int CNTW = 8;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int CH   = P + 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [7:0]      in_data = 8'h00;
    logic            in_sof = 1'b0;
    logic            in_eof = 1'b0;
    logic            in_ready;
    logic [CNTW-1:0] credits = '0;
    logic [CNTW-1:0] rx_avail = '0;
    logic            irq_pend = 1'b0;
    logic            burst_start = 1'b0;
    logic            busy, out_valid, burst_done;
    logic [7:0]      out_data;
    logic [CW-1:0]   burst_chunks;

    tx_chunk_packer #(.PAYLOAD_BYTES(P), .MAX_CHUNKS(MAXC), .CNT_W(CNTW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready),
        .credits(credits), .rx_avail(rx_avail), .irq_pend(irq_pend),
        .burst_start(burst_start), .busy(busy), .out_valid(out_valid),
        .out_data(out_data), .burst_done(burst_done), .burst_chunks(burst_chunks)
    );

    always #2.5 clk = ~clk;

    int         checks = 0;
    int         errors = 0;
    logic [9:0] drvq[$];
    logic [9:0] mq[$];
    logic [7:0] got[$];
    logic [7:0] expb[$];
    int         kinds[$];
    bit         done_seen = 0;
    int         got_cnt = 0;
    bit         fire_pend = 0;
    bit         hung = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Output monitor, away from the active edge.
    always @(negedge clk) begin
        if (out_valid) got.push_back(out_data);
        if (burst_done) begin
            done_seen = 1;
            got_cnt   = int'(burst_chunks);
        end
    end

    // Input stream driver: pops after an accepted byte, presents the next.
    initial begin
        forever begin
            @(negedge clk);
            if (fire_pend && drvq.size() > 0) void'(drvq.pop_front());
            if (drvq.size() > 0) begin
                in_valid = 1'b1;
                {in_sof, in_eof, in_data} = drvq[0];
            end else begin
                in_valid = 1'b0;
                in_sof = 1'b0;
                in_eof = 1'b0;
                in_data = 8'h00;
            end
            fire_pend = in_valid && in_ready;
        end
    end

    function automatic logic [31:0] ref_hdr(input bit dv, input bit sv, input bit ev, input int eo);
        logic [31:0] w;
        w = 32'h8000_0000;
        w[21] = dv;
        w[20] = sv;
        w[14] = ev;
        w[13:8] = 6'(eo);
        w[0] = ($countones(w) % 2 == 0) ? 1'b1 : 1'b0;
        return w;
    endfunction

    task automatic push_frame(input int len);
        for (int i = 0; i < len; i++) begin
            logic [9:0] e;
            e = {(i == 0) ? 1'b1 : 1'b0, (i == len - 1) ? 1'b1 : 1'b0, 8'($urandom)};
            drvq.push_back(e);
            mq.push_back(e);
        end
    endtask

    task automatic push_word(input logic [31:0] w);
        expb.push_back(w[31:24]);
        expb.push_back(w[23:16]);
        expb.push_back(w[15:8]);
        expb.push_back(w[7:0]);
    endtask

    // Reference chunk stream for one burst, consuming the mirror queue.
    task automatic build_expected(input int cred, input int rxav, input bit irq, output int cnt);
        int cc, d, fill;
        expb.delete();
        kinds.delete();
        cc = (cred > MAXC) ? MAXC : cred;
        d = 0;
        while (d < cc && mq.size() > 0) begin
            logic [7:0] pay[P];
            int n;
            bit sv, ev;
            n = 0;
            ev = 0;
            sv = mq[0][9];
            while (n < P && !ev && mq.size() > 0) begin
                logic [9:0] e;
                e = mq.pop_front();
                pay[n] = e[7:0];
                ev = e[8];
                n++;
            end
            push_word(ref_hdr(1, sv, ev, ev ? n - 1 : 0));
            for (int i = 0; i < P; i++) expb.push_back((i < n) ? pay[i] : 8'h00);
            kinds.push_back(1);
            d++;
        end
        fill = (rxav > d) ? rxav - d : 0;
        if (fill > MAXC - d) fill = MAXC - d;
        if (d == 0 && fill == 0 && irq) fill = 1;
        for (int f = 0; f < fill; f++) begin
            push_word(ref_hdr(0, 0, 0, 0));
            for (int i = 0; i < P; i++) expb.push_back(8'h00);
            kinds.push_back(0);
        end
        cnt = d + fill;
    endtask

    task automatic run_burst(input string tag, input int cred, input int rxav, input bit irq);
        int cnt, w, bad;
        if (hung) return;
        build_expected(cred, rxav, irq, cnt);
        got.delete();
        done_seen = 0;
        @(negedge clk);
        burst_start = 1'b1;
        credits = CNTW'(cred);
        rx_avail = CNTW'(rxav);
        irq_pend = irq;
        @(negedge clk);
        burst_start = 1'b0;
        w = 0;
        while (!done_seen && w < 30000) begin
            @(negedge clk);
            w++;
        end
        if (!done_seen) begin
            hung = 1;
            chk("watchdog R10 burst never ended", 0, 1);
            return;
        end
        chk({tag, " chunk count"}, got_cnt, cnt);
        chk("R1 burst byte length", got.size(), cnt * CH);
        bad = -1;
        for (int i = 0; i < got.size() && i < expb.size(); i++) begin
            if (bad < 0 && got[i] !== expb[i]) bad = i;
        end
        if (bad >= 0) begin
            int k, pos;
            string t;
            k = bad / CH;
            pos = bad % CH;
            if (kinds[k] == 0) t = "R7 filler byte";
            else if (pos < 4) t = "R2 header byte";
            else t = "R3 payload byte";
            $display("  mismatch at burst byte %0d (chunk %0d pos %0d)", bad, k, pos);
            chk(t, got[bad], expb[bad]);
        end else begin
            chk("R2 R3 R7 stream content", 0, 0);
        end
    endtask

    function automatic int gb(input int i);
        return (i < got.size()) ? int'(got[i]) : -1;
    endfunction

    initial begin
        void'($urandom(32'h5EED_0A11));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 out_valid in reset", out_valid, 0);
        chk("R11 in_ready in reset", in_ready, 0);
        chk("R11 busy in reset", busy, 0);
        chk("R11 burst_done in reset", burst_done, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 out_valid after reset", out_valid, 0);
        chk("R11 busy after reset", busy, 0);

        // R10: nothing to send
        run_burst("R10 empty burst", 5, 0, 0);
        chk("R10 no bytes", got.size(), 0);

        // R8: interrupt alone gives one empty chunk
        run_burst("R8 irq only", 0, 0, 1);
        // R8: interrupt with backlog adds nothing
        run_burst("R8 irq with backlog", 0, 3, 1);

        // R5: frame of exactly one payload
        push_frame(64);
        run_burst("R5 full chunk frame", 2, 0, 0);
        chk("R5 end flag and offset 63", gb(2), 8'h7F);

        // R5: one-byte frame
        push_frame(1);
        run_burst("R5 single byte frame", 1, 0, 0);
        chk("R5 end flag and offset 0", gb(2), 8'h40);
        chk("R4 start flag on first chunk", (gb(1) >> 4) & 1, 1);

        // R6 R4: frame split across bursts by credit
        push_frame(130);
        run_burst("R6 one credit", 1, 0, 0);
        chk("R4 start flag set on first piece", (gb(1) >> 4) & 1, 1);
        chk("R5 no end flag on first piece", (gb(2) >> 6) & 1, 0);
        run_burst("R6 carried remainder", 5, 0, 0);
        chk("R4 no start flag on continuation", (gb(1) >> 4) & 1, 0);
        chk("R5 end offset of short tail", gb(CH + 2), 8'h41);

        // R6 R7: no credit, frame waits, fillers pull receive data
        push_frame(10);
        run_burst("R6 zero credit fillers", 0, 2, 0);
        run_burst("R6 waiting frame sent", 200, 0, 0);

        // R9: filler trimmed at the burst cap
        run_burst("R9 cap 48", 3, 60, 0);

        // Randomised bursts
        for (int it = 0; it < 30; it++) begin
            if ($urandom % 2 == 0) push_frame(1 + int'($urandom % 200));
            if ($urandom % 4 == 0) push_frame(1 + int'($urandom % 70));
            run_burst("R6 R7 R8 random", int'($urandom % 8), int'($urandom % 10), 1'($urandom % 2));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule